// File: doc/BRIEF.md
# Two-Step Residue-Integrating SAR Conversion Sequencer

This block sequences one complete conversion of a two-step successive-approximation converter that integrates its residue. After an accepted start in normal mode, it first runs an 8-bit coarse binary search against the comparator. It then holds the coarse code on the DAC as the input estimate for 32 integration cycles and records one loop bit from each cycle. Last, it runs an 8-bit fine search on the integrated residue using the same procedure.

In calibration mode there is no coarse search. Two codes supplied with the start are latched. The first drives the DAC branch that normally takes the analog input. The second stands in for the coarse estimate. The integration and fine phases then run as in normal mode. The comparator answers each trial with a one-cycle valid strobe, so the sequencer waits for as long as the analog side needs. Any arithmetic on the three results is left to logic downstream.

Top module: `risar_seq`

## Requirements
- R1: After reset `busy`, `done`, `dac_trial`, `dac_est_code`, `dac_in_code`, `dac_use_code` are 0 and `phase` is 0 (idle).
- R2: A start seen in idle is accepted at that clock edge, and `cal_mode`, `cal_code_a` and `cal_code_b` are sampled only then. In normal mode the next cycle shows `phase` = 1 (coarse) and `dac_trial` = 8'h80.
- R3: A search step happens only on a cycle with `cmp_valid` = 1. `cmp_high` = 1 keeps the bit under trial and `cmp_high` = 0 clears it. The next lower bit is then set. After the decision on bit 0 the search ends, and the coarse result appears on `coarse_q`.
- R4: The integration phase (`phase` = 2) takes exactly 32 `cmp_valid` strobes. The `cmp_high` of strobe j (counting from 0) is stored in `dsm_q[j]`, and `dsm_q` is cleared when the phase begins.
- R5: Throughout integration `dac_est_code` equals the coarse estimate and does not change. In normal mode `dac_in_code` = 0 and `dac_use_code` = 0. In calibration mode `dac_in_code` = latched code A and `dac_use_code` = 1. Outside integration all three are 0.
- R6: The cycle after the 32nd integration strobe shows `phase` = 3 (fine) and `dac_trial` = 8'h80. The fine search follows R3 and its result appears on `fine_q`.
- R7: In calibration mode the cycle after acceptance already shows `phase` = 2, and `coarse_q` equals the latched code B.
- R8: `done` is 1 for exactly one cycle, the cycle after the final fine decision (`phase` = 4). `coarse_q`, `fine_q` and `dsm_q` hold their values while idle.
- R9: A start while `busy` is ignored, and so are the mode and codes presented with it. In idle and done, `cmp_valid` changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request |
| cal_mode | input | 1 | 1 = calibration run, 0 = normal conversion |
| cal_code_a | input | 8 | Calibration code for the input-equivalent DAC branch |
| cal_code_b | input | 8 | Calibration code used as the coarse estimate |
| cmp_valid | input | 1 | Comparator decision strobe |
| cmp_high | input | 1 | Comparator result: 1 = input above trial level |
| dac_trial | output | 8 | Trial code during coarse and fine searches |
| dac_est_code | output | 8 | Coarse estimate applied during integration |
| dac_in_code | output | 8 | Code for the input branch during calibration integration |
| dac_use_code | output | 1 | Input branch takes `dac_in_code` instead of the analog input |
| phase | output | 3 | 0 idle, 1 coarse, 2 integrate, 3 fine, 4 done |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle completion pulse |
| coarse_q | output | 8 | Coarse result, or code B in calibration |
| fine_q | output | 8 | Fine result |
| dsm_q | output | 32 | Loop bits captured during integration |

## Verification
The bench models the comparator as a threshold against a target value, so a correct search must land on that target. The targets cover all-ones, all-zeros, alternating bits and mid-scale. These tell keep/clear polarity errors apart from bit-order errors, and the expected trial sequence is rebuilt step by step. Loop-bit patterns are asymmetric and single-bit, which exposes reversed or shifted capture indices. Varying the gaps between strobes shows that steps wait for the comparator. Calibration runs with distinct A and B codes separate the two DAC roles. A start injected mid-run with calibration settings, and strobes sent while idle, check that both are ignored.

// File: rtl/risar_pkg.sv
package risar_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_COARSE = 3'd1,
    PH_INTEG  = 3'd2,
    PH_FINE   = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;
endpackage

// File: rtl/risar_search.sv
module risar_search #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         decide,
  output logic [W-1:0] trial,
  output logic [W-1:0] result,
  output logic         fin
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] trial_q, trial_d;
  logic [W-1:0] mask_q, mask_d;

  always_comb begin
    trial_d = trial_q;
    mask_d  = mask_q;
    result  = decide ? trial_q : (trial_q & ~mask_q);
    if (load) begin
      trial_d = TOP_BIT;
      mask_d  = TOP_BIT;
    end else if (step) begin
      mask_d  = mask_q >> 1;
      trial_d = result | (mask_q >> 1);
    end
  end

  assign fin   = step & mask_q[0];
  assign trial = trial_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else if (load || step) begin
      trial_q <= trial_d;
      mask_q  <= mask_d;
    end
  end

  // R3: only one bit is ever under trial
  a_r3_single_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));
  // R3: a high decision keeps the bit just tried
  a_r3_keep_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (step && decide && !load) |=> ((trial_q & $past(mask_q)) == $past(mask_q)));
  // R3: a low decision clears the bit just tried
  a_r3_clear_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !decide && !load) |=> ((trial_q & $past(mask_q)) == '0));
endmodule

// File: rtl/risar_integ.sv
module risar_integ #(
  parameter int LOG2N = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             bit_in,
  output logic [(1<<LOG2N)-1:0] bits,
  output logic             last
);
  localparam int N = 1 << LOG2N;
  localparam logic [LOG2N-1:0] CNT_END = LOG2N'(N - 1);

  logic [LOG2N-1:0] cnt_q, cnt_d;
  logic [N-1:0]     bits_q, bits_d;

  always_comb begin
    cnt_d  = cnt_q;
    bits_d = bits_q;
    if (load) begin
      cnt_d  = '0;
      bits_d = '0;
    end else if (step) begin
      bits_d[cnt_q] = bit_in;
      cnt_d         = cnt_q + 1'b1;
    end
  end

  assign last = step & (cnt_q == CNT_END);
  assign bits = bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bits_q <= '0;
    end else if (load || step) begin
      cnt_q  <= cnt_d;
      bits_q <= bits_d;
    end
  end

  // R4: the phase starts with an empty bit record
  a_r4_clear_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bits_q == '0));
  // R4: each strobe alters at most one recorded bit
  a_r4_one_bit_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ($countones(bits_q ^ $past(bits_q)) <= 1));
  // R4: count only moves on a strobe
  a_r4_count_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/risar_seq.sv
module risar_seq
  import risar_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int INTEG_LOG = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      cal_mode,
  input  logic [CODE_W-1:0]         cal_code_a,
  input  logic [CODE_W-1:0]         cal_code_b,
  input  logic                      cmp_valid,
  input  logic                      cmp_high,
  output logic [CODE_W-1:0]         dac_trial,
  output logic [CODE_W-1:0]         dac_est_code,
  output logic [CODE_W-1:0]         dac_in_code,
  output logic                      dac_use_code,
  output logic [2:0]                phase,
  output logic                      busy,
  output logic                      done,
  output logic [CODE_W-1:0]         coarse_q,
  output logic [CODE_W-1:0]         fine_q,
  output logic [(1<<INTEG_LOG)-1:0] dsm_q
);
  localparam logic [CODE_W-1:0] TOP_BIT = {1'b1, {(CODE_W-1){1'b0}}};

  phase_e state_q, state_d;
  logic              mode_q;
  logic [CODE_W-1:0] code_a_q;
  logic [CODE_W-1:0] coarse_r, fine_r;

  logic accept, in_search, in_integ;
  logic sar_load, sar_step, sar_fin;
  logic int_load, int_step, int_last;
  logic [CODE_W-1:0] sar_trial, sar_res;

  assign accept    = (state_q == PH_IDLE) && start;
  assign in_search = (state_q == PH_COARSE) || (state_q == PH_FINE);
  assign in_integ  = (state_q == PH_INTEG);

  assign sar_step = cmp_valid && in_search;
  assign int_step = cmp_valid && in_integ;
  assign sar_load = (accept && !cal_mode) || int_last;
  assign int_load = ((state_q == PH_COARSE) && sar_fin) || (accept && cal_mode);

  risar_search #(.W(CODE_W)) i_search (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (sar_load),
    .step   (sar_step),
    .decide (cmp_high),
    .trial  (sar_trial),
    .result (sar_res),
    .fin    (sar_fin)
  );

  risar_integ #(.LOG2N(INTEG_LOG)) i_integ (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (int_load),
    .step   (int_step),
    .bit_in (cmp_high),
    .bits   (dsm_q),
    .last   (int_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:   if (accept)   state_d = cal_mode ? PH_INTEG : PH_COARSE;
      PH_COARSE: if (sar_fin)  state_d = PH_INTEG;
      PH_INTEG:  if (int_last) state_d = PH_FINE;
      PH_FINE:   if (sar_fin)  state_d = PH_DONE;
      PH_DONE:                 state_d = PH_IDLE;
      default:                 state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      code_a_q <= '0;
    end else if (accept) begin
      mode_q   <= cal_mode;
      code_a_q <= cal_code_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_r <= '0;
    end else if (accept && cal_mode) begin
      coarse_r <= cal_code_b;
    end else if ((state_q == PH_COARSE) && sar_fin) begin
      coarse_r <= sar_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_r <= '0;
    end else if ((state_q == PH_FINE) && sar_fin) begin
      fine_r <= sar_res;
    end
  end

  assign dac_trial    = in_search ? sar_trial : '0;
  assign dac_est_code = in_integ ? coarse_r : '0;
  assign dac_in_code  = (in_integ && mode_q) ? code_a_q : '0;
  assign dac_use_code = in_integ && mode_q;
  assign phase        = state_q;
  assign busy         = (state_q != PH_IDLE);
  assign done         = (state_q == PH_DONE);
  assign coarse_q     = coarse_r;
  assign fine_q       = fine_r;

  // R8: completion strobe lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: the estimate stays fixed for the whole integration phase
  a_r5_est_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_integ && $past(in_integ)) |-> $stable(dac_est_code));
  // R9: a start while busy leaves the latched mode alone
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q));
  // R7: calibration goes straight to integration
  a_r7_cal_skips_coarse: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cal_mode) |=> (state_q == PH_INTEG));
  // R6: the fine search opens from the top bit after the last loop bit
  a_r6_fine_opens_top: assert property (@(posedge clk) disable iff (!rst_n)
    int_last |=> ((state_q == PH_FINE) && (dac_trial == TOP_BIT)));
  // R8: results hold while idle
  a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PH_IDLE) && $past(state_q == PH_IDLE)) |-> ($stable(fine_q) && $stable(dsm_q)));
endmodule

// File: tb/test_risar_seq.sv
module test_risar_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, cal_mode, cmp_valid, cmp_high;
  logic [7:0]  cal_code_a, cal_code_b;
  logic [7:0]  dac_trial, dac_est_code, dac_in_code, coarse_q, fine_q;
  logic        dac_use_code, busy, done;
  logic [2:0]  phase;
  logic [31:0] dsm_q;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  risar_seq i_risar_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cal_mode(cal_mode),
    .cal_code_a(cal_code_a), .cal_code_b(cal_code_b),
    .cmp_valid(cmp_valid), .cmp_high(cmp_high),
    .dac_trial(dac_trial), .dac_est_code(dac_est_code), .dac_in_code(dac_in_code),
    .dac_use_code(dac_use_code), .phase(phase), .busy(busy), .done(done),
    .coarse_q(coarse_q), .fine_q(fine_q), .dsm_q(dsm_q)
  );

  typedef struct packed {
    logic        cal;
    logic [7:0]  x;
    logic [7:0]  y;
    logic [31:0] e;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [1:0]  gap;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'hFF, 8'h00, 32'h0000_0001, 8'h00, 8'h00, 2'd0},
    '{1'b0, 8'h00, 8'hFF, 32'h8000_0000, 8'h00, 8'h00, 2'd1},
    '{1'b0, 8'hA5, 8'h5A, 32'hF0E1_D2C3, 8'h00, 8'h00, 2'd2},
    '{1'b0, 8'h80, 8'h7F, 32'hAAAA_5555, 8'h00, 8'h00, 2'd0},
    '{1'b1, 8'h00, 8'h3C, 32'h1234_5678, 8'h96, 8'h4B, 2'd1},
    '{1'b1, 8'h00, 8'h81, 32'h0000_FFFF, 8'h01, 8'hFE, 2'd0},
    '{1'b0, 8'h01, 8'h80, 32'hFFFF_FFFF, 8'h00, 8'h00, 2'd3}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic hi, input int gap);
    repeat (gap) @(negedge clk);
    cmp_valid = 1'b1;
    cmp_high  = hi;
    @(negedge clk);
    cmp_valid = 1'b0;
    cmp_high  = 1'b0;
  endtask

  // Runs one 8-bit search against target; returns whether every trial matched.
  task automatic search(input logic [7:0] target, input int gap, input bit poke, output bit seq_ok);
    logic [7:0] exp;
    exp    = 8'h80;
    seq_ok = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      logic hi;
      if (dac_trial !== exp) seq_ok = 1'b0;
      hi = (target >= exp);
      if (poke && k == 4) begin
        start = 1'b1; cal_mode = 1'b1; cal_code_a = 8'h33; cal_code_b = 8'h55;
      end
      strobe(hi, gap);
      start = 1'b0; cal_mode = 1'b0; cal_code_a = 8'h00; cal_code_b = 8'h00;
      if (!hi) exp[k] = 1'b0;
      if (k > 0) exp[k-1] = 1'b1;
    end
  endtask

  task automatic run(input vec_t v, input bit poke);
    bit ok;
    logic [7:0] est;
    est = v.cal ? v.b : v.x;
    @(negedge clk);
    start = 1'b1; cal_mode = v.cal; cal_code_a = v.a; cal_code_b = v.b;
    @(negedge clk);
    start = 1'b0; cal_mode = 1'b0; cal_code_a = 8'h00; cal_code_b = 8'h00;
    if (!v.cal) begin
      chk(phase == 3'd1 && dac_trial == 8'h80, "R2 coarse entry", {21'd0, phase, dac_trial}, {24'h1, 8'h80});
      search(v.x, v.gap, poke, ok);
      chk(ok, "R3 coarse trial sequence", 32'(ok), 32'd1);
      chk(coarse_q == v.x, "R3 coarse result", 32'(coarse_q), 32'(v.x));
    end else begin
      chk(phase == 3'd2, "R7 calibration skips coarse", 32'(phase), 32'd2);
      chk(coarse_q == v.b, "R7 coarse reports code B", 32'(coarse_q), 32'(v.b));
    end
    chk(phase == 3'd2 && dac_est_code == est, "R5 estimate at entry",
        {21'd0, phase, dac_est_code}, {24'h2, est});
    chk(dac_use_code == v.cal && dac_in_code == (v.cal ? v.a : 8'h00), "R5 input branch",
        {23'd0, dac_use_code, dac_in_code}, {23'd0, v.cal, (v.cal ? v.a : 8'h00)});
    chk(dsm_q == 32'd0, "R4 record cleared", dsm_q, 32'd0);
    for (int j = 0; j < 32; j++) begin
      if (j == 31)
        chk(phase == 3'd2 && dac_est_code == est, "R5 estimate before last strobe",
            {21'd0, phase, dac_est_code}, {24'h2, est});
      strobe(v.e[j], v.gap);
    end
    chk(phase == 3'd3 && dac_trial == 8'h80, "R6 fine entry", {21'd0, phase, dac_trial}, {24'h3, 8'h80});
    chk(dac_est_code == 8'h00 && dac_use_code == 1'b0, "R5 released after integration",
        {23'd0, dac_use_code, dac_est_code}, 32'd0);
    search(v.y, v.gap, 1'b0, ok);
    chk(ok, "R6 fine trial sequence", 32'(ok), 32'd1);
    chk(done == 1'b1 && phase == 3'd4, "R8 done after last decision", {28'd0, done, phase}, {28'd1, 3'd4});
    chk(fine_q == v.y, "R6 fine result", 32'(fine_q), 32'(v.y));
    chk(coarse_q == est, "R3 coarse kept", 32'(coarse_q), 32'(est));
    chk(dsm_q == v.e, "R4 loop bits", dsm_q, v.e);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 done single cycle", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cal_mode = 1'b0; cmp_valid = 1'b0; cmp_high = 1'b0;
    cal_code_a = 8'h00; cal_code_b = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && phase == 0 && dac_trial == 0 && dac_est_code == 0 &&
        dac_in_code == 0 && dac_use_code == 0, "R1 reset state",
        {busy, done, phase, dac_use_code, dac_trial, dac_est_code, 2'b0, dac_in_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);

    // R9: start with calibration settings during a coarse search is ignored
    run('{1'b0, 8'h6D, 8'h92, 32'h0F0F_00FF, 8'h00, 8'h00, 2'd0}, 1'b1);

    // R9: strobes while idle change nothing
    begin
      logic [7:0] c0, f0;
      logic [31:0] e0;
      c0 = coarse_q; f0 = fine_q; e0 = dsm_q;
      for (int k = 0; k < 4; k++) strobe(k[0], 0);
      chk(coarse_q == c0 && fine_q == f0 && dsm_q == e0 && phase == 0 && dac_trial == 0,
          "R9 idle strobes ignored", {24'd0, coarse_q}, {24'd0, c0});
      chk(dsm_q == e0, "R8 results held while idle", dsm_q, e0);
    end

    // R1: reset in the middle of integration
    @(negedge clk);
    start = 1'b1; cal_mode = 1'b1; cal_code_a = 8'h11; cal_code_b = 8'h22;
    @(negedge clk);
    start = 1'b0; cal_mode = 1'b0;
    strobe(1'b1, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && phase == 0 && dac_use_code == 0 && dac_est_code == 0,
        "R1 reset mid-run", {27'd0, busy, done, phase}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule